// File: doc/BRIEF.md
# Event Projection-Field Controller

This controller sequences the work for one tile of an event-driven convolution engine. Address events arrive on a four-phase request/acknowledge port. Each event carries a 7-bit x and y coordinate in a 128x128 input space and a sign bit. The tile owns a 32x32 pixel array. Configuration inputs place the array's lower corner anywhere in the input space, so several tiles can listen to one shared event bus.

For every accepted event, the controller centres the programmed kernel (width and height 1 to 32) on the event coordinate. It works out which array rows and columns the kernel covers and clips away anything that falls outside the array. It then copies the surviving kernel rows one at a time from an external kernel memory into the pixel weight registers, with the column shift already applied. When the last row is written, it pulses one of two global integration strobe lines for a fixed number of cycles. The event sign selects which line. If no part of the kernel lands on the array, the controller copies nothing and fires no strobe, but the handshake still completes.

The request is assumed to be synchronous to `clk_i`. The configuration inputs are assumed to be stable while an event is being processed.

Top module: `aer_proj_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, `ev_ack_o`, `kmem_rd_o`, `pix_we_o`, `strobe_pos_o` and `strobe_neg_o` are all low.
- R2: A request seen at a clock edge while the controller is idle and `ev_ack_o` is low latches the event and raises `ev_ack_o` after that edge. `ev_ack_o` stays high while the request is high. It falls one cycle after the request drops. No new event is accepted until the strobe of the current event has ended.
- R3: Define the row offset as `rs = y - floor((kh-1)/2) - org_y`. Array row `r` receives kernel row `r - rs`. Only rows with `0 <= r <= 31` and `0 <= r - rs < kh` are written. They are written in ascending order, once each.
- R4: Define the column shift as `s = x - floor((kw-1)/2) - org_x`. It is output as a two's-complement value on `col_shift_o`. In each row write, 4-bit column field `c` of `pix_data_o` (bits `4c+3:4c`) holds kernel column `c - s` from kernel memory field `c - s`. Fields whose kernel column lies outside `0..kw-1` are zero.
- R5: Kernels of even size centre with the extra element on the high-coordinate side. For example, kw=6 places kernel column 0 at x-2.
- R6: After the last row write, exactly one strobe line is high for STROBE_LEN (default 2) consecutive cycles. The line is `strobe_pos_o` for event sign 0 and `strobe_neg_o` for sign 1. No kernel read or row write happens during the strobe.
- R7: With N rows to copy, the accept edge is followed by one placement cycle, then two cycles per row (read, then write), then the strobe. The event takes 2N+4 cycles in total at the default strobe width.
- R8: If the clipped field is empty in rows or in columns, no kernel read, no row write and no strobe occur, and the handshake still completes.
- R9: Every row write is preceded in the previous cycle by a kernel read. The read row address `kmem_row_o` equals the kernel row `r - rs`, and the memory returns the data one cycle after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ev_req_i | input | 1 | Event request |
| ev_x_i | input | 7 | Event x coordinate |
| ev_y_i | input | 7 | Event y coordinate |
| ev_sign_i | input | 1 | Event sign, 1 = negative |
| ev_ack_o | output | 1 | Event acknowledge |
| cfg_org_x_i | input | 7 | Array corner x in the input space |
| cfg_org_y_i | input | 7 | Array corner y in the input space |
| cfg_kw_i | input | 6 | Kernel width, 1..32 |
| cfg_kh_i | input | 6 | Kernel height, 1..32 |
| kmem_rd_o | output | 1 | Kernel memory read strobe |
| kmem_row_o | output | 5 | Kernel row to read |
| kmem_data_i | input | 128 | Kernel row data, 32 fields of 4 bits |
| pix_we_o | output | 1 | Pixel row write enable |
| pix_row_o | output | 5 | Array row being written |
| pix_data_o | output | 128 | Shifted row weights, 32 fields of 4 bits |
| col_shift_o | output | 9 | Column shift s, two's complement |
| strobe_pos_o | output | 1 | Integration strobe for positive events |
| strobe_neg_o | output | 1 | Integration strobe for negative events |

## Verification
The assertions check the cycle-level rules on every cycle. Each row write must follow a kernel read, the two strobe lines are never high together, and the strobe never overlaps copy traffic. The acknowledge must rise only after a request and must follow the request as it is held and released. Only the bench's scenarios can show the arithmetic: the clipped row range, the kernel row addresses, the shifted column contents and the exact event length. These need placements fully inside the array, partly over each edge and entirely off the array, plus a request that arrives while the controller is busy.

// File: rtl/aer_pf_pkg.sv
package aer_pf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PLACE = 3'd1,
    ST_READ  = 3'd2,
    ST_WRITE = 3'd3,
    ST_FIRE  = 3'd4
  } pf_state_e;
endpackage

// File: rtl/aer_ev_port.sv
module aer_ev_port #(
  parameter int ADDR_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] x_i,
  input  logic [ADDR_W-1:0] y_i,
  input  logic              sign_i,
  input  logic              ready_i,
  output logic              accept_o,
  output logic              ack_o,
  output logic [ADDR_W-1:0] x_o,
  output logic [ADDR_W-1:0] y_o,
  output logic              sign_o
);
  logic ack_q;

  assign accept_o = ready_i & req_i & ~ack_q;
  assign ack_o    = ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
      sign_o <= 1'b0;
    end else begin
      if (accept_o) begin
        ack_q  <= 1'b1;
        x_o    <= x_i;
        y_o    <= y_i;
        sign_o <= sign_i;
      end else if (!req_i) begin
        ack_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/aer_field_place.sv
module aer_field_place #(
  parameter int ADDR_W  = 7,
  parameter int ARR_LOG = 5,
  parameter int KW_W    = 6,
  localparam int OFF_W  = ADDR_W + 2,
  localparam int ARR_N  = 1 << ARR_LOG
) (
  input  logic [ADDR_W-1:0]       ev_x_i,
  input  logic [ADDR_W-1:0]       ev_y_i,
  input  logic [ADDR_W-1:0]       org_x_i,
  input  logic [ADDR_W-1:0]       org_y_i,
  input  logic [KW_W-1:0]         kw_i,
  input  logic [KW_W-1:0]         kh_i,
  output logic signed [OFF_W-1:0] row_off_o,
  output logic signed [OFF_W-1:0] col_off_o,
  output logic [ARR_LOG-1:0]      first_row_o,
  output logic [ARR_LOG-1:0]      last_row_o,
  output logic                    miss_o
);
  localparam logic signed [OFF_W-1:0] LAST = OFF_W'(ARR_N - 1);

  logic [KW_W-1:0]         hx_u, hy_u;
  logic signed [OFF_W-1:0] rs, cs, re, ce;

  // low-side half span; even sizes lean to the high side
  assign hx_u = (kw_i - KW_W'(1)) >> 1;
  assign hy_u = (kh_i - KW_W'(1)) >> 1;

  assign rs = $signed(OFF_W'(ev_y_i)) - $signed(OFF_W'(hy_u)) - $signed(OFF_W'(org_y_i));
  assign cs = $signed(OFF_W'(ev_x_i)) - $signed(OFF_W'(hx_u)) - $signed(OFF_W'(org_x_i));
  assign re = rs + $signed(OFF_W'(kh_i)) - $signed(OFF_W'(1));
  assign ce = cs + $signed(OFF_W'(kw_i)) - $signed(OFF_W'(1));

  assign row_off_o   = rs;
  assign col_off_o   = cs;
  assign miss_o      = (re < 0) || (rs > LAST) || (ce < 0) || (cs > LAST);
  assign first_row_o = (rs < 0) ? '0 : rs[ARR_LOG-1:0];
  assign last_row_o  = (re > LAST) ? LAST[ARR_LOG-1:0] : re[ARR_LOG-1:0];
endmodule

// File: rtl/aer_row_shift.sv
module aer_row_shift #(
  parameter int ARR_N = 32,
  parameter int KMAX  = 32,
  parameter int WB    = 4,
  parameter int OFF_W = 9,
  parameter int KW_W  = 6,
  localparam int KI_W = $clog2(KMAX)
) (
  input  logic [KMAX*WB-1:0]      krow_i,
  input  logic signed [OFF_W-1:0] col_off_i,
  input  logic [KW_W-1:0]         kw_i,
  output logic [ARR_N*WB-1:0]     prow_o
);
  for (genvar c = 0; c < ARR_N; c++) begin : g_col
    logic signed [OFF_W:0] idx;
    logic [KI_W-1:0]       idx_u;
    logic                  in_k;
    assign idx   = $signed((OFF_W+1)'(c)) - $signed({col_off_i[OFF_W-1], col_off_i});
    assign idx_u = idx[KI_W-1:0];
    assign in_k  = (idx >= 0) && (idx < $signed((OFF_W+1)'(kw_i)));
    assign prow_o[c*WB +: WB] = in_k ? krow_i[WB*int'(idx_u) +: WB] : '0;
  end
endmodule

// File: rtl/aer_proj_ctrl.sv
module aer_proj_ctrl #(
  parameter int ADDR_W     = 7,
  parameter int ARR_LOG    = 5,
  parameter int KMAX       = 32,
  parameter int WB         = 4,
  parameter int STROBE_LEN = 2,
  localparam int ARR_N     = 1 << ARR_LOG,
  localparam int KW_W      = $clog2(KMAX) + 1,
  localparam int KR_W      = $clog2(KMAX),
  localparam int OFF_W     = ADDR_W + 2,
  localparam int STB_W     = $clog2(STROBE_LEN + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ev_req_i,
  input  logic [ADDR_W-1:0]   ev_x_i,
  input  logic [ADDR_W-1:0]   ev_y_i,
  input  logic                ev_sign_i,
  output logic                ev_ack_o,
  input  logic [ADDR_W-1:0]   cfg_org_x_i,
  input  logic [ADDR_W-1:0]   cfg_org_y_i,
  input  logic [KW_W-1:0]     cfg_kw_i,
  input  logic [KW_W-1:0]     cfg_kh_i,
  output logic                kmem_rd_o,
  output logic [KR_W-1:0]     kmem_row_o,
  input  logic [KMAX*WB-1:0]  kmem_data_i,
  output logic                pix_we_o,
  output logic [ARR_LOG-1:0]  pix_row_o,
  output logic [ARR_N*WB-1:0] pix_data_o,
  output logic [OFF_W-1:0]    col_shift_o,
  output logic                strobe_pos_o,
  output logic                strobe_neg_o
);
  import aer_pf_pkg::*;

  pf_state_e               state_q;
  logic                    accept;
  logic [ADDR_W-1:0]       lx, ly;
  logic                    lsign;
  logic signed [OFF_W-1:0] p_row_off, p_col_off;
  logic [ARR_LOG-1:0]      p_first, p_last;
  logic                    p_miss;
  logic signed [OFF_W-1:0] row_off_q, col_off_q;
  logic [ARR_LOG-1:0]      row_q, last_q;
  logic [STB_W-1:0]        stb_q;
  logic signed [OFF_W-1:0] krow_s;

  aer_ev_port #(.ADDR_W(ADDR_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (ev_req_i),
    .x_i     (ev_x_i),
    .y_i     (ev_y_i),
    .sign_i  (ev_sign_i),
    .ready_i (state_q == ST_IDLE),
    .accept_o(accept),
    .ack_o   (ev_ack_o),
    .x_o     (lx),
    .y_o     (ly),
    .sign_o  (lsign)
  );

  aer_field_place #(.ADDR_W(ADDR_W), .ARR_LOG(ARR_LOG), .KW_W(KW_W)) u_place (
    .ev_x_i     (lx),
    .ev_y_i     (ly),
    .org_x_i    (cfg_org_x_i),
    .org_y_i    (cfg_org_y_i),
    .kw_i       (cfg_kw_i),
    .kh_i       (cfg_kh_i),
    .row_off_o  (p_row_off),
    .col_off_o  (p_col_off),
    .first_row_o(p_first),
    .last_row_o (p_last),
    .miss_o     (p_miss)
  );

  aer_row_shift #(.ARR_N(ARR_N), .KMAX(KMAX), .WB(WB), .OFF_W(OFF_W), .KW_W(KW_W)) u_shift (
    .krow_i   (kmem_data_i),
    .col_off_i(col_off_q),
    .kw_i     (cfg_kw_i),
    .prow_o   (pix_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      row_off_q <= '0;
      col_off_q <= '0;
      row_q     <= '0;
      last_q    <= '0;
      stb_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (accept) state_q <= ST_PLACE;
        ST_PLACE: begin
          row_off_q <= p_row_off;
          col_off_q <= p_col_off;
          row_q     <= p_first;
          last_q    <= p_last;
          state_q   <= p_miss ? ST_IDLE : ST_READ;
        end
        ST_READ:  state_q <= ST_WRITE;
        ST_WRITE: begin
          if (row_q == last_q) begin
            stb_q   <= '0;
            state_q <= ST_FIRE;
          end else begin
            row_q   <= row_q + ARR_LOG'(1);
            state_q <= ST_READ;
          end
        end
        ST_FIRE: begin
          stb_q <= stb_q + STB_W'(1);
          if (stb_q == STB_W'(STROBE_LEN - 1)) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign krow_s       = $signed(OFF_W'(row_q)) - row_off_q;
  assign kmem_row_o   = krow_s[KR_W-1:0];
  assign kmem_rd_o    = (state_q == ST_READ);
  assign pix_we_o     = (state_q == ST_WRITE);
  assign pix_row_o    = row_q;
  assign col_shift_o  = col_off_q;
  assign strobe_pos_o = (state_q == ST_FIRE) & ~lsign;
  assign strobe_neg_o = (state_q == ST_FIRE) &  lsign;
endmodule

// File: rtl/aer_proj_ctrl_chk.sv
module aer_proj_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ev_req_i,
  input logic ev_ack_o,
  input logic kmem_rd_o,
  input logic pix_we_o,
  input logic strobe_pos_o,
  input logic strobe_neg_o
);
  p_one_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_pos_o && strobe_neg_o));

  p_quiet_strobe_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_pos_o || strobe_neg_o) |-> !(kmem_rd_o || pix_we_o));

  p_we_after_rd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |-> $past(kmem_rd_o));

  p_rd_then_we_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kmem_rd_o |=> pix_we_o);

  p_ack_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ev_ack_o) |-> $past(ev_req_i));

  p_ack_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_ack_o && ev_req_i) |=> ev_ack_o);

  p_ack_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_ack_o && !ev_req_i) |=> !ev_ack_o);
endmodule

bind aer_proj_ctrl aer_proj_ctrl_chk u_chk (.*);

// File: tb/aer_proj_ctrl_bench.sv
module aer_proj_ctrl_bench;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         ev_req_i = 1'b0;
  logic [6:0]   ev_x_i = '0, ev_y_i = '0;
  logic         ev_sign_i = 1'b0;
  logic         ev_ack_o;
  logic [6:0]   cfg_org_x_i = 7'd32, cfg_org_y_i = 7'd32;
  logic [5:0]   cfg_kw_i = 6'd3, cfg_kh_i = 6'd3;
  logic         kmem_rd_o;
  logic [4:0]   kmem_row_o;
  logic [127:0] kmem_q = '0;
  logic         pix_we_o;
  logic [4:0]   pix_row_o;
  logic [127:0] pix_data_o;
  logic [8:0]   col_shift_o;
  logic         strobe_pos_o, strobe_neg_o;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #2 clk_i = ~clk_i;

  aer_proj_ctrl u_aer_proj_ctrl (.*, .kmem_data_i(kmem_q));

  function automatic logic [3:0] kval(int j, int k);
    return 4'((j * 5 + k * 3 + 1) & 15);
  endfunction

  function automatic logic [127:0] krow(int j);
    logic [127:0] r = '0;
    for (int k = 0; k < 32; k++) r[k*4 +: 4] = kval(j, k);
    return r;
  endfunction

  function automatic logic [127:0] exp_row(int j, int s, int kw);
    logic [127:0] r = '0;
    for (int c = 0; c < 32; c++)
      if (c - s >= 0 && c - s < kw) r[c*4 +: 4] = kval(j, c - s);
    return r;
  endfunction

  always @(posedge clk_i) if (kmem_rd_o) kmem_q <= krow(int'(kmem_row_o));

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, act=%0d exp<100000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  typedef struct packed {
    logic [6:0] x, y;
    logic       sg;
    logic [5:0] kw, kh;
    logic [6:0] ox, oy;
    logic       miss;
    logic signed [8:0] rs;
    logic [5:0] n;
    logic signed [8:0] s;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{7'd40, 7'd40, 1'b0, 6'd3,  6'd3,  7'd32, 7'd32, 1'b0,  9'sd7,  6'd3,  9'sd7},
    '{7'd48, 7'd48, 1'b1, 6'd32, 6'd32, 7'd32, 7'd32, 1'b0,  9'sd1,  6'd31, 9'sd1},
    '{7'd30, 7'd31, 1'b1, 6'd5,  6'd4,  7'd32, 7'd32, 1'b0, -9'sd2,  6'd2, -9'sd4},
    '{7'd10, 7'd10, 1'b0, 6'd3,  6'd3,  7'd32, 7'd32, 1'b1, -9'sd23, 6'd0, -9'sd23},
    '{7'd100,7'd40, 1'b0, 6'd3,  6'd3,  7'd32, 7'd32, 1'b1,  9'sd7,  6'd0,  9'sd67},
    '{7'd63, 7'd63, 1'b0, 6'd1,  6'd1,  7'd32, 7'd32, 1'b0,  9'sd31, 6'd1,  9'sd31},
    '{7'd2,  7'd30, 1'b1, 6'd6,  6'd7,  7'd0,  7'd0,  1'b0,  9'sd27, 6'd5,  9'sd0},
    '{7'd62, 7'd50, 1'b0, 6'd8,  6'd2,  7'd32, 7'd32, 1'b0,  9'sd18, 6'd2,  9'sd27}
  };

  task automatic run_vec(vec_t v);
    int first, n, s, rs, wi, ri, nstb, t0stb, tmax;
    rs = int'(v.rs); s = int'(v.s); n = int'(v.n);
    first = rs < 0 ? 0 : rs;
    wi = 0; ri = 0; nstb = 0; t0stb = -1;
    tmax = 2 * n + 8;
    @(negedge clk_i);
    ev_x_i = v.x; ev_y_i = v.y; ev_sign_i = v.sg;
    cfg_kw_i = v.kw; cfg_kh_i = v.kh; cfg_org_x_i = v.ox; cfg_org_y_i = v.oy;
    ev_req_i = 1'b1;
    for (int t = 1; t <= tmax; t++) begin
      @(negedge clk_i);
      if (t == 1) chk(ev_ack_o == 1'b1, "R2 ack rise", ev_ack_o, 1);
      if (kmem_rd_o) begin
        chk(int'(kmem_row_o) == first + ri - rs, "R9 kernel row", kmem_row_o, first + ri - rs);
        ri++;
      end
      if (pix_we_o) begin
        chk(int'(pix_row_o) == first + wi, "R3 array row", pix_row_o, first + wi);
        chk(t == 3 + 2 * wi, "R7 write cycle", t, 3 + 2 * wi);
        chk($signed(col_shift_o) == s, "R4 shift", $signed(col_shift_o), s);
        chk(pix_data_o == exp_row(int'(pix_row_o) - rs, s, int'(v.kw)), "R4 R5 row data",
            pix_data_o[63:0], exp_row(int'(pix_row_o) - rs, s, int'(v.kw)) & 64'hFFFF_FFFF_FFFF_FFFF);
        wi++;
      end
      if (strobe_pos_o || strobe_neg_o) begin
        chk(strobe_neg_o == v.sg && strobe_pos_o == !v.sg, "R6 strobe line", strobe_neg_o, v.sg);
        if (t0stb < 0) t0stb = t;
        nstb++;
      end
    end
    chk(wi == n, v.miss ? "R8 no writes" : "R3 row count", wi, n);
    chk(nstb == (v.miss ? 0 : 2), v.miss ? "R8 no strobe" : "R6 strobe width", nstb, v.miss ? 0 : 2);
    if (!v.miss) chk(t0stb == 2 * n + 2, "R7 strobe start", t0stb, 2 * n + 2);
    else chk(ri == 0, "R8 no reads", ri, 0);
    chk(ev_ack_o == 1'b1, "R2 ack held", ev_ack_o, 1);
    ev_req_i = 1'b0;
    @(negedge clk_i);
    chk(ev_ack_o == 1'b0, v.miss ? "R8 handshake done" : "R2 ack fall", ev_ack_o, 0);
    @(negedge clk_i);
  endtask

  initial begin
    int wa, wb, t_ack;
    #1;
    chk(!ev_ack_o && !kmem_rd_o && !pix_we_o && !strobe_pos_o && !strobe_neg_o,
        "R1 in reset", {ev_ack_o, kmem_rd_o, pix_we_o, strobe_pos_o, strobe_neg_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    chk(!ev_ack_o && !kmem_rd_o && !pix_we_o && !strobe_pos_o && !strobe_neg_o,
        "R1 after reset", {ev_ack_o, kmem_rd_o, pix_we_o, strobe_pos_o, strobe_neg_o}, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R2: a second request while busy must wait for the strobe to end
    cfg_kw_i = 6'd3; cfg_kh_i = 6'd3; cfg_org_x_i = 7'd32; cfg_org_y_i = 7'd32;
    @(negedge clk_i);
    ev_x_i = 7'd40; ev_y_i = 7'd40; ev_sign_i = 1'b0; ev_req_i = 1'b1;
    wa = 0; wb = 0; t_ack = -1;
    for (int t = 1; t <= 30; t++) begin
      @(negedge clk_i);
      if (t == 1) ev_req_i = 1'b0;
      if (t == 2) begin
        chk(ev_ack_o == 1'b0, "R2 ack drop busy", ev_ack_o, 0);
        ev_x_i = 7'd41; ev_req_i = 1'b1;
      end
      if (t >= 3 && ev_ack_o && t_ack < 0) t_ack = t;
      if (pix_we_o) begin
        if (t < 11) begin
          chk($signed(col_shift_o) == 7, "R2 first event kept", $signed(col_shift_o), 7);
          wa++;
        end else begin
          chk($signed(col_shift_o) == 8, "R2 second event", $signed(col_shift_o), 8);
          wb++;
        end
      end
    end
    chk(t_ack == 11, "R2 accept after strobe", t_ack, 11);
    chk(wa == 3 && wb == 3, "R2 both events copied", wa * 10 + wb, 33);
    ev_req_i = 1'b0;
    repeat (2) @(negedge clk_i);
    chk(ev_ack_o == 1'b0, "R2 final release", ev_ack_o, 0);

    summary();
    $finish;
  end
endmodule